// File: doc/BRIEF.md
# Chamber Strip-to-Phi Coordinate Converter

This block turns a local trigger primitive from one chamber into an azimuthal coordinate that is valid across the whole trigger sector. Each primitive carries a half-strip number and a 4-bit strip-pattern code. A static chamber-type selector picks the angular pitch of that chamber. The half-strip is scaled by a per-type factor, and a fixed 10-bit starting angle for the chamber is added. A small correction, looked up from the pattern code, then fills in the two finest bits of a 12-bit sector phi.

The factor is exactly 1 for the standard chambers, so no multiplier is used for them. It is 2 for the wide chambers, where a one-bit shift does the work. Three chamber types need a true fractional factor; for these the block uses an unsigned constant with 8 fractional bits and rounds the product to the nearest integer. The conversion runs as a three-stage pipeline: scale, add the starting angle, then apply the correction. A valid flag travels alongside the data through every stage. If the sum exceeds the 10-bit coordinate range, the output saturates.

Top module: `phi_strip_converter`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid result arrives, `out_valid` is 0 and `phi_out` is 0.
- R2: A primitive sampled with `in_valid` high on a rising clock edge appears at the outputs after the third rising edge, counting that edge as the first. `out_valid` is high for exactly those cycles.
- R3: For chamber type code 0, the factor is 1: `phi_out[11:2]` = `base_phi` + the full 8-bit `half_strip`.
- R4: For type code 1, the factor is 2: `phi_out[11:2]` = `base_phi` + 2 × `half_strip[6:0]`. Bit 7 of `half_strip` has no effect.
- R5: Type codes 2, 3 and 4 use the fractional multipliers 427/256, 326/256 and 237/256. The scaled value is (h × K + 128) >> 8. Here h is `half_strip[6:0]` for codes 2 and 3, and the full 8 bits for code 4. `phi_out[11:2]` = `base_phi` + that value.
- R6: Type codes 5, 6 and 7 behave exactly like code 0.
- R7: `phi_out[1:0]` is entry p of `CORR_TABLE`, where p is the `pattern` input and entry p is bits [2p+1:2p]. The default table is 32'h9C36E41B.
- R8: When `base_phi` plus the scaled half-strip exceeds 1023, `phi_out` is 4095, whatever the correction.
- R9: In a cycle where `out_valid` is low, `phi_out` keeps the last valid result.
- R10: Primitives may arrive on consecutive cycles with any mix of types, offsets and patterns. Each result depends only on its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Primitive present this cycle |
| half_strip | input | 8 | Half-strip number within the chamber |
| pattern | input | 4 | Strip-pattern code that indexes the correction table |
| chamber_type | input | 3 | Chamber type code that selects the scale factor |
| base_phi | input | 10 | Fixed starting phi of the chamber in the sector |
| out_valid | output | 1 | Result valid |
| phi_out | output | 12 | Corrected sector phi |

## Verification
The hardest condition to reach is the saturation boundary. The sum must land just at or just above 1023, and for the fractional types only a narrow band of half-strips produces a given rounded value. Uniform random offsets seldom land there. The stimulus therefore draws `base_phi` from the top quarter of the range for about half of the random vectors. It also applies directed vectors that sit exactly at 1023 and at 1024. Further directed vectors set bit 7 of the half-strip on the seven-bit types, and use the reserved type codes, to show that both are ignored.

// File: rtl/phi_conv_pkg.sv
package phi_conv_pkg;

    localparam int FRAC_W = 8;
    localparam int K_W    = 9;

    typedef enum logic [2:0] {
        CH_UNIT     = 3'd0,
        CH_DOUBLE   = 3'd1,
        CH_FRAC_HI  = 3'd2,
        CH_FRAC_MID = 3'd3,
        CH_FRAC_LO  = 3'd4
    } chamber_e;

    // fractional scale factors, 8 fractional bits
    localparam logic [K_W-1:0] K_HI  = 9'd427;
    localparam logic [K_W-1:0] K_MID = 9'd326;
    localparam logic [K_W-1:0] K_LO  = 9'd237;

endpackage

// File: rtl/phi_scale_stage.sv
module phi_scale_stage
    import phi_conv_pkg::*;
#(
    parameter int HS_W   = 8,
    parameter int PHI_W  = 10,
    parameter int PAT_W  = 4,
    localparam int SC_W  = HS_W + 1,
    localparam int PROD_W = HS_W + K_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [HS_W-1:0]  hs_i,
    input  logic [2:0]       ctype_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [PHI_W-1:0] base_i,
    output logic             v_o,
    output logic [SC_W-1:0]  scaled_o,
    output logic [PAT_W-1:0] pat_o,
    output logic [PHI_W-1:0] base_o
);

    localparam logic [PROD_W-1:0] ROUND_HALF = PROD_W'(1) << (FRAC_W - 1);

    logic [HS_W-1:0]   hs_narrow;
    logic [HS_W-1:0]   mul_src;
    logic [K_W-1:0]    mul_k;
    logic              use_frac;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_rnd;
    logic [SC_W-1:0]   direct_val;
    logic [SC_W-1:0]   scaled_c;

    assign hs_narrow = {1'b0, hs_i[HS_W-2:0]};

    always_comb begin
        use_frac   = 1'b0;
        mul_src    = hs_i;
        mul_k      = K_LO;
        direct_val = {1'b0, hs_i};
        case (ctype_i)
            CH_UNIT:     direct_val = {1'b0, hs_i};
            CH_DOUBLE:   direct_val = {hs_narrow, 1'b0};
            CH_FRAC_HI: begin
                use_frac = 1'b1;
                mul_src  = hs_narrow;
                mul_k    = K_HI;
            end
            CH_FRAC_MID: begin
                use_frac = 1'b1;
                mul_src  = hs_narrow;
                mul_k    = K_MID;
            end
            CH_FRAC_LO: begin
                use_frac = 1'b1;
                mul_src  = hs_i;
                mul_k    = K_LO;
            end
            default:     direct_val = {1'b0, hs_i};
        endcase
    end

    assign prod     = PROD_W'(mul_src) * PROD_W'(mul_k);
    assign prod_rnd = prod + ROUND_HALF;
    assign scaled_c = use_frac ? prod_rnd[FRAC_W +: SC_W] : direct_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o      <= 1'b0;
            scaled_o <= '0;
            pat_o    <= '0;
            base_o   <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                scaled_o <= scaled_c;
                pat_o    <= pat_i;
                base_o   <= base_i;
            end
        end
    end

endmodule

// File: rtl/phi_offset_stage.sv
module phi_offset_stage #(
    parameter int SC_W  = 9,
    parameter int PHI_W = 10,
    parameter int PAT_W = 4,
    localparam int SUM_W = PHI_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [SC_W-1:0]  scaled_i,
    input  logic [PHI_W-1:0] base_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic             v_o,
    output logic [PHI_W-1:0] sum_o,
    output logic             sat_o,
    output logic [PAT_W-1:0] pat_o
);

    logic [SUM_W-1:0] sum_c;

    assign sum_c = SUM_W'(base_i) + SUM_W'(scaled_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            sum_o <= '0;
            sat_o <= 1'b0;
            pat_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                sum_o <= sum_c[PHI_W-1:0];
                sat_o <= sum_c[PHI_W];
                pat_o <= pat_i;
            end
        end
    end

endmodule

// File: rtl/phi_correct_stage.sv
module phi_correct_stage #(
    parameter int PHI_W  = 10,
    parameter int PAT_W  = 4,
    parameter int CORR_W = 2,
    localparam int ENTRIES = 1 << PAT_W,
    localparam int OUT_W   = PHI_W + CORR_W,
    parameter logic [ENTRIES*CORR_W-1:0] TABLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [PHI_W-1:0] sum_i,
    input  logic             sat_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic             v_o,
    output logic [OUT_W-1:0] phi_o
);

    logic [CORR_W-1:0] corr_rom [ENTRIES];
    logic [OUT_W-1:0]  phi_c;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_rom
        assign corr_rom[e] = TABLE[e*CORR_W +: CORR_W];
    end

    assign phi_c = sat_i ? {OUT_W{1'b1}} : {sum_i, corr_rom[pat_i]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            phi_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                phi_o <= phi_c;
            end
        end
    end

endmodule

// File: rtl/phi_strip_converter.sv
module phi_strip_converter #(
    parameter int HS_W   = 8,
    parameter int PHI_W  = 10,
    parameter int PAT_W  = 4,
    parameter int CORR_W = 2,
    localparam int SC_W  = HS_W + 1,
    localparam int OUT_W = PHI_W + CORR_W,
    parameter logic [(1<<PAT_W)*CORR_W-1:0] CORR_TABLE = 32'h9C36E41B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [HS_W-1:0]  half_strip,
    input  logic [PAT_W-1:0] pattern,
    input  logic [2:0]       chamber_type,
    input  logic [PHI_W-1:0] base_phi,
    output logic             out_valid,
    output logic [OUT_W-1:0] phi_out
);

    logic             s1_v;
    logic [SC_W-1:0]  s1_scaled;
    logic [PAT_W-1:0] s1_pat;
    logic [PHI_W-1:0] s1_base;
    logic             s2_v;
    logic [PHI_W-1:0] s2_sum;
    logic             s2_sat;
    logic [PAT_W-1:0] s2_pat;

    phi_scale_stage #(
        .HS_W(HS_W), .PHI_W(PHI_W), .PAT_W(PAT_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n),
        .v_i(in_valid), .hs_i(half_strip), .ctype_i(chamber_type),
        .pat_i(pattern), .base_i(base_phi),
        .v_o(s1_v), .scaled_o(s1_scaled), .pat_o(s1_pat), .base_o(s1_base)
    );

    phi_offset_stage #(
        .SC_W(SC_W), .PHI_W(PHI_W), .PAT_W(PAT_W)
    ) u_offset (
        .clk(clk), .rst_n(rst_n),
        .v_i(s1_v), .scaled_i(s1_scaled), .base_i(s1_base), .pat_i(s1_pat),
        .v_o(s2_v), .sum_o(s2_sum), .sat_o(s2_sat), .pat_o(s2_pat)
    );

    phi_correct_stage #(
        .PHI_W(PHI_W), .PAT_W(PAT_W), .CORR_W(CORR_W), .TABLE(CORR_TABLE)
    ) u_correct (
        .clk(clk), .rst_n(rst_n),
        .v_i(s2_v), .sum_i(s2_sum), .sat_i(s2_sat), .pat_i(s2_pat),
        .v_o(out_valid), .phi_o(phi_out)
    );

endmodule

// File: rtl/phi_strip_converter_chk.sv
module phi_strip_converter_chk #(
    parameter int HS_W   = 8,
    parameter int PHI_W  = 10,
    parameter int PAT_W  = 4,
    parameter int CORR_W = 2,
    localparam int OUT_W = PHI_W + CORR_W,
    parameter logic [(1<<PAT_W)*CORR_W-1:0] CORR_TABLE = 32'h9C36E41B
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [HS_W-1:0]  half_strip,
    input logic [PAT_W-1:0] pattern,
    input logic [2:0]       chamber_type,
    input logic [PHI_W-1:0] base_phi,
    input logic             out_valid,
    input logic [OUT_W-1:0] phi_out
);

    localparam logic [OUT_W-1:0] SAT_VAL = {OUT_W{1'b1}};

    logic [1:0] since_rst;
    logic       deep;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign deep = (since_rst == 2'd3);
    assign warm = (since_rst != 2'd0);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && phi_out == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        deep |-> (out_valid == $past(in_valid, 3)));

    assert_unit_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (deep && out_valid && $past(chamber_type, 3) == 3'd0 && phi_out != SAT_VAL)
        |-> ({1'b0, phi_out[OUT_W-1:CORR_W]} ==
             ({1'b0, $past(base_phi, 3)} + (PHI_W+1)'($past(half_strip, 3)))));

    assert_double_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (deep && out_valid && $past(chamber_type, 3) == 3'd1 && phi_out != SAT_VAL)
        |-> ({1'b0, phi_out[OUT_W-1:CORR_W]} ==
             ({1'b0, $past(base_phi, 3)} +
              (PHI_W+1)'({$past(half_strip[HS_W-2:0], 3), 1'b0}))));

    assert_corr_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (deep && out_valid && phi_out != SAT_VAL)
        |-> (phi_out[CORR_W-1:0] ==
             CORR_TABLE[$past(pattern, 3)*CORR_W +: CORR_W]));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !out_valid) |-> $stable(phi_out));

endmodule

bind phi_strip_converter phi_strip_converter_chk #(
    .HS_W(HS_W), .PHI_W(PHI_W), .PAT_W(PAT_W), .CORR_W(CORR_W),
    .CORR_TABLE(CORR_TABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_strip(half_strip),
    .pattern(pattern), .chamber_type(chamber_type), .base_phi(base_phi),
    .out_valid(out_valid), .phi_out(phi_out)
);

// File: tb/phi_strip_converter_test.sv
module phi_strip_converter_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TB_TABLE = 32'h9C36E41B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  half_strip;
    logic [3:0]  pattern;
    logic [2:0]  chamber_type;
    logic [9:0]  base_phi;
    logic        out_valid;
    logic [11:0] phi_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    logic  ev [3];
    logic [11:0] ep [3];
    string et [3];
    logic [11:0] model_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phi_strip_converter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_strip(half_strip),
        .pattern(pattern), .chamber_type(chamber_type), .base_phi(base_phi),
        .out_valid(out_valid), .phi_out(phi_out)
    );

    function automatic int scaled_of(input logic [2:0] ty, input logic [7:0] hs);
        int h8 = int'(hs);
        int h7 = int'(hs[6:0]);
        case (ty)
            3'd1:    return 2 * h7;                  // R4
            3'd2:    return (h7 * 427 + 128) / 256;  // R5
            3'd3:    return (h7 * 326 + 128) / 256;  // R5
            3'd4:    return (h8 * 237 + 128) / 256;  // R5
            default: return h8;                      // R3, R6
        endcase
    endfunction

    function automatic logic [11:0] ref_phi(input logic [2:0] ty, input logic [7:0] hs,
                                            input logic [9:0] base, input logic [3:0] pat);
        int total = int'(base) + scaled_of(ty, hs);
        logic [1:0] corr = TB_TABLE[2*pat +: 2];     // R7
        if (total > 1023) return 12'hFFF;            // R8
        return {10'(total), corr};
    endfunction

    function automatic string ref_tag(input logic [2:0] ty, input logic [7:0] hs,
                                      input logic [9:0] base);
        if (int'(base) + scaled_of(ty, hs) > 1023) return "R8 R2";
        case (ty)
            3'd0:    return "R3 R7 R2 R10";
            3'd1:    return "R4 R7 R2 R10";
            3'd2, 3'd3, 3'd4: return "R5 R7 R2 R10";
            default: return "R6 R7 R2 R10";
        endcase
    endfunction

    task automatic check_out(input logic exp_v, input logic [11:0] exp_p, input string tag);
        n_checks++;
        if (out_valid !== exp_v || phi_out !== exp_p) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b phi=%0d, expected valid=%0b phi=%0d",
                     tag, out_valid, phi_out, exp_v, exp_p);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] hs, input logic [3:0] pat,
                        input logic [2:0] ty, input logic [9:0] base);
        check_out(ev[2], ep[2], et[2]);
        ev[2] = ev[1]; ep[2] = ep[1]; et[2] = et[1];
        ev[1] = ev[0]; ep[1] = ep[0]; et[1] = et[0];
        if (v) begin
            model_last = ref_phi(ty, hs, base, pat);
            et[0] = ref_tag(ty, hs, base);
        end else begin
            et[0] = "R9 R2";
        end
        ev[0] = v;
        ep[0] = model_last;
        in_valid     = v;
        half_strip   = hs;
        pattern      = pat;
        chamber_type = ty;
        base_phi     = base;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no completion, expected end of run");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin
            ev[i] = 1'b0; ep[i] = '0; et[i] = "R9";
        end
        rst_n = 1'b0; in_valid = 1'b1; half_strip = 8'hFF; pattern = 4'hF;
        chamber_type = 3'd0; base_phi = 10'h3FF;
        repeat (3) @(negedge clk);
        check_out(1'b0, 12'd0, "R1");               // R1 during reset
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_out(1'b0, 12'd0, "R1");               // R1 after release

        step(1, 8'd200, 4'd5, 3'd0, 10'd300);     // R3
        step(1, 8'h85, 4'd0, 3'd1, 10'd10);       // R4 bit 7 ignored
        step(1, 8'h05, 4'd1, 3'd1, 10'd10);       // R4
        step(1, 8'd127, 4'd2, 3'd2, 10'd0);       // R5
        step(1, 8'hE4, 4'd3, 3'd3, 10'd7);        // R5 bit 7 ignored
        step(1, 8'd255, 4'd15, 3'd4, 10'd1);      // R5 full width
        step(0, 8'd99, 4'd9, 3'd0, 10'd99);       // R9 gap
        step(0, 8'd11, 4'd4, 3'd2, 10'd512);      // R9 gap
        step(1, 8'd50, 4'd6, 3'd5, 10'd60);       // R6
        step(1, 8'd50, 4'd7, 3'd7, 10'd60);       // R6
        step(1, 8'd255, 4'd8, 3'd0, 10'd768);     // R8 boundary, 1023
        step(1, 8'd255, 4'd8, 3'd0, 10'd769);     // R8 just over
        step(1, 8'd255, 4'd12, 3'd0, 10'd1023);   // R8
        step(1, 8'd127, 4'd13, 3'd2, 10'd812);    // R8 at 1024 via rounding
        step(1, 8'd127, 4'd13, 3'd2, 10'd811);    // R5 at 1023

        for (int n = 0; n < 3000; n++) begin       // R10 random mix
            logic [9:0] b;
            b = 10'($urandom);
            if ($urandom % 2 == 0) b = {2'b11, b[7:0]};
            step(($urandom % 4) != 0, 8'($urandom), 4'($urandom),
                 3'($urandom), b);
        end
        for (int n = 0; n < 4; n++) step(0, 8'd0, 4'd0, 3'd0, 10'd0);

        done = 1;
        finish_run();
    end

endmodule